// File: doc/BRIEF.md
# Masked Vector Compress and Expand Unit

This block rearranges the elements of one vector register under a per-element select mask. In compress mode it collects the elements whose mask bit is set and packs them at the low end of the result. Their ascending index order is kept. The result elements above the packed run are cleared to zero. In expand mode it performs the inverse placement: consecutive source elements, starting at element 0, land in the result positions whose mask bit is set, and every position with a clear mask bit keeps the value of the old destination vector supplied alongside.

Both modes report a length equal to the number of set mask bits. In compress mode this is the length of the packed vector. In expand mode it is the number of source elements consumed. One request is accepted per valid cycle, and each result appears exactly one clock later. Arithmetic and memory access are left to neighbouring blocks.

Top module: `vcx_unit`

## Requirements
- R1: In compress mode (`in_op` = 0), result element k, for k below the set-bit count, equals the source element at the position of the (k+1)-th set mask bit counted upward from bit 0. Element i of any vector port occupies bits [i*ELEM_W +: ELEM_W].
- R2: In compress mode, every result element at an index equal to or above the set-bit count is zero.
- R3: `out_len` equals the number of set bits in the mask of the accepted request, in both modes.
- R4: In expand mode (`in_op` = 1), the result element at the position of the (k+1)-th set mask bit, counted upward from bit 0, equals source element k.
- R5: In expand mode, every result element whose mask bit is clear equals the same element of `in_old`.
- R6: `out_done` is high in the cycle after an accepted request (`in_valid` high at a rising edge) and low after any edge at which `in_valid` was low.
- R7: While `in_valid` is low, `out_vec` and `out_len` keep their values, whatever the other inputs do.
- R8: After reset, `out_done` is 0, `out_len` is 0 and `out_vec` is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| in_op | input | 1 | 0 = compress, 1 = expand |
| in_mask | input | NUM_ELEM | Select bit per element |
| in_src | input | NUM_ELEM*ELEM_W | Source vector |
| in_old | input | NUM_ELEM*ELEM_W | Prior destination vector, used by expand |
| out_vec | output | NUM_ELEM*ELEM_W | Result vector |
| out_len | output | $clog2(NUM_ELEM+1) | Set-bit count of the accepted mask |
| out_done | output | 1 | Result valid, one cycle after the request |

## Verification
The bench runs all 256 masks of the default eight-element configuration in both modes. Every source and old element carries a value unique to its index and to the mask, so a result element taken from the wrong position, from the wrong vector or in the wrong order shows up as a distinct value. The empty and full masks separate a packed run of zero length from the identity placement. Masks with a single bit set at either end test the edges of the rank logic. Idle cycles with scrambled inputs between requests show that the result is held. A back-to-back pair of requests shows that each result belongs to its own request.

// File: rtl/vcx_pkg.sv
package vcx_pkg;
  typedef enum logic [0:0] {
    VCX_COMPRESS = 1'b0,
    VCX_EXPAND   = 1'b1
  } vcx_op_e;
endpackage

// File: rtl/vcx_rank.sv
// Exclusive prefix count of the mask: rank of each element among the set bits.
module vcx_rank #(
  parameter int NUM_ELEM = 8,
  parameter int LEN_W    = $clog2(NUM_ELEM + 1)
) (
  input  logic [NUM_ELEM-1:0]       mask,
  output logic [NUM_ELEM*LEN_W-1:0] rank,
  output logic [LEN_W-1:0]          total
);
  logic [LEN_W-1:0] acc;

  always_comb begin
    acc = '0;
    for (int i = 0; i < NUM_ELEM; i++) begin
      rank[i*LEN_W +: LEN_W] = acc;
      acc = acc + LEN_W'(mask[i]);
    end
    total = acc;
  end
endmodule

// File: rtl/vcx_pack.sv
// Compress network: result slot j takes the selected element whose rank is j.
module vcx_pack #(
  parameter int NUM_ELEM = 8,
  parameter int ELEM_W   = 64,
  parameter int LEN_W    = $clog2(NUM_ELEM + 1)
) (
  input  logic [NUM_ELEM-1:0]        mask,
  input  logic [NUM_ELEM*LEN_W-1:0]  rank,
  input  logic [NUM_ELEM*ELEM_W-1:0] src,
  output logic [NUM_ELEM*ELEM_W-1:0] packed_vec
);
  for (genvar j = 0; j < NUM_ELEM; j++) begin : g_slot
    logic [ELEM_W-1:0] slot;
    always_comb begin
      slot = '0;
      for (int i = 0; i < NUM_ELEM; i++) begin
        if (mask[i] && (rank[i*LEN_W +: LEN_W] == LEN_W'(j)))
          slot = slot | src[i*ELEM_W +: ELEM_W];
      end
    end
    assign packed_vec[j*ELEM_W +: ELEM_W] = slot;
  end
endmodule

// File: rtl/vcx_spread.sv
// Expand network: a selected position i reads source element rank(i).
module vcx_spread #(
  parameter int NUM_ELEM = 8,
  parameter int ELEM_W   = 64,
  parameter int LEN_W    = $clog2(NUM_ELEM + 1)
) (
  input  logic [NUM_ELEM-1:0]        mask,
  input  logic [NUM_ELEM*LEN_W-1:0]  rank,
  input  logic [NUM_ELEM*ELEM_W-1:0] src,
  input  logic [NUM_ELEM*ELEM_W-1:0] old_vec,
  output logic [NUM_ELEM*ELEM_W-1:0] spread_vec
);
  localparam int IDX_W = (NUM_ELEM > 1) ? $clog2(NUM_ELEM) : 1;

  logic [ELEM_W-1:0] src_a [NUM_ELEM];

  for (genvar i = 0; i < NUM_ELEM; i++) begin : g_unflat
    assign src_a[i] = src[i*ELEM_W +: ELEM_W];
  end

  for (genvar i = 0; i < NUM_ELEM; i++) begin : g_pos
    logic [LEN_W-1:0] r;
    assign r = rank[i*LEN_W +: LEN_W];
    assign spread_vec[i*ELEM_W +: ELEM_W] =
      mask[i] ? src_a[r[IDX_W-1:0]] : old_vec[i*ELEM_W +: ELEM_W];
  end
endmodule

// File: rtl/vcx_unit.sv
module vcx_unit #(
  parameter int NUM_ELEM = 8,
  parameter int ELEM_W   = 64,
  parameter int LEN_W    = $clog2(NUM_ELEM + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic                       in_op,
  input  logic [NUM_ELEM-1:0]        in_mask,
  input  logic [NUM_ELEM*ELEM_W-1:0] in_src,
  input  logic [NUM_ELEM*ELEM_W-1:0] in_old,
  output logic [NUM_ELEM*ELEM_W-1:0] out_vec,
  output logic [LEN_W-1:0]           out_len,
  output logic                       out_done
);
  import vcx_pkg::*;

  localparam int VEC_W = NUM_ELEM * ELEM_W;

  logic [NUM_ELEM*LEN_W-1:0] rank;
  logic [LEN_W-1:0]          total;
  logic [VEC_W-1:0]          packed_vec;
  logic [VEC_W-1:0]          spread_vec;
  vcx_op_e                   op;

  logic [VEC_W-1:0] vec_nxt, vec_q;
  logic [LEN_W-1:0] len_nxt, len_q;
  logic             done_nxt, done_q;
  logic             load_en;

  vcx_rank #(.NUM_ELEM(NUM_ELEM), .LEN_W(LEN_W)) i_rank (
    .mask (in_mask),
    .rank (rank),
    .total(total)
  );

  vcx_pack #(.NUM_ELEM(NUM_ELEM), .ELEM_W(ELEM_W), .LEN_W(LEN_W)) i_pack (
    .mask      (in_mask),
    .rank      (rank),
    .src       (in_src),
    .packed_vec(packed_vec)
  );

  vcx_spread #(.NUM_ELEM(NUM_ELEM), .ELEM_W(ELEM_W), .LEN_W(LEN_W)) i_spread (
    .mask      (in_mask),
    .rank      (rank),
    .src       (in_src),
    .old_vec   (in_old),
    .spread_vec(spread_vec)
  );

  assign op      = vcx_op_e'(in_op);
  assign load_en = in_valid;

  always_comb begin
    vec_nxt  = (op == VCX_EXPAND) ? spread_vec : packed_vec;
    len_nxt  = total;
    done_nxt = in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q  <= '0;
      len_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= done_nxt;
      if (load_en) begin
        vec_q <= vec_nxt;
        len_q <= len_nxt;
      end
    end
  end

  assign out_vec  = vec_q;
  assign out_len  = len_q;
  assign out_done = done_q;
endmodule

// File: rtl/vcx_unit_chk.sv
module vcx_unit_chk #(
  parameter int NUM_ELEM = 8,
  parameter int ELEM_W   = 64,
  parameter int LEN_W    = $clog2(NUM_ELEM + 1)
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       in_valid,
  input logic                       in_op,
  input logic [NUM_ELEM-1:0]        in_mask,
  input logic [NUM_ELEM*ELEM_W-1:0] in_old,
  input logic [NUM_ELEM*ELEM_W-1:0] out_vec,
  input logic [LEN_W-1:0]           out_len,
  input logic                       out_done
);
  AST_DONE_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_done); // R6
  AST_DONE_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_done); // R6
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_vec) && $stable(out_len))); // R7
  AST_LEN_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (32'(out_len) == $countones($past(in_mask)))); // R3

  for (genvar j = 0; j < NUM_ELEM; j++) begin : g_elem
    AST_PACK_TAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_op && ($countones(in_mask) <= j))
      |=> (out_vec[j*ELEM_W +: ELEM_W] == '0)); // R2
    AST_SPREAD_KEEP_OLD: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_op && !in_mask[j])
      |=> (out_vec[j*ELEM_W +: ELEM_W] == $past(in_old[j*ELEM_W +: ELEM_W]))); // R5
  end
endmodule

bind vcx_unit vcx_unit_chk #(.NUM_ELEM(NUM_ELEM), .ELEM_W(ELEM_W), .LEN_W(LEN_W)) i_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .in_valid(in_valid),
  .in_op   (in_op),
  .in_mask (in_mask),
  .in_old  (in_old),
  .out_vec (out_vec),
  .out_len (out_len),
  .out_done(out_done)
);

// File: tb/test_vcx_unit.sv
`timescale 1ns/1ps
module test_vcx_unit;
  localparam int N     = 8;
  localparam int W     = 64;
  localparam int LEN_W = $clog2(N + 1);

  logic             clk;
  logic             rst_n;
  logic             in_valid;
  logic             in_op;
  logic [N-1:0]     in_mask;
  logic [N*W-1:0]   in_src;
  logic [N*W-1:0]   in_old;
  logic [N*W-1:0]   out_vec;
  logic [LEN_W-1:0] out_len;
  logic             out_done;

  int tests;
  int fails;
  bit finished;

  vcx_unit #(.NUM_ELEM(N), .ELEM_W(W)) i_vcx_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_mask(in_mask), .in_src(in_src), .in_old(in_old),
    .out_vec(out_vec), .out_len(out_len), .out_done(out_done)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [W-1:0] src_val(int m, int i);
    return {8'hA0 + 8'(i), 8'(m), 16'h5A5A, 32'(i * 977 + m * 13 + 1)};
  endfunction

  function automatic logic [W-1:0] old_val(int m, int i);
    return {8'hC0 + 8'(i), 8'(m), 16'h3C3C, 32'(i * 31 + m * 7 + 5)};
  endfunction

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp, int idx);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s elem %0d: actual %h expected %h", tag, idx, act, exp);
    end
  endtask

  task automatic apply(int op, int m);
    in_valid = 1'b1;
    in_op    = op[0];
    in_mask  = m[N-1:0];
    for (int i = 0; i < N; i++) begin
      in_src[i*W +: W] = src_val(m, i);
      in_old[i*W +: W] = old_val(m, i);
    end
  endtask

  task automatic verify(int op, int m);
    logic [W-1:0] exp [N];
    int k;
    int cnt;
    cnt = 0;
    for (int i = 0; i < N; i++) if (m[i]) cnt++;
    k = 0;
    if (op == 0) begin
      for (int i = 0; i < N; i++) exp[i] = '0;
      for (int i = 0; i < N; i++) if (m[i]) begin exp[k] = src_val(m, i); k++; end
      for (int i = 0; i < N; i++)
        check((i < cnt) ? "R1" : "R2", out_vec[i*W +: W], exp[i], i);
    end else begin
      for (int i = 0; i < N; i++) begin
        if (m[i]) begin
          exp[i] = src_val(m, k);
          k++;
          check("R4", out_vec[i*W +: W], exp[i], i);
        end else begin
          check("R5", out_vec[i*W +: W], old_val(m, i), i);
        end
      end
    end
    check("R3", W'(out_len), W'(cnt), -1);
    check("R6", W'(out_done), W'(1), -1);
  endtask

  task automatic one_request(int op, int m);
    logic [N*W-1:0]   held_vec;
    logic [LEN_W-1:0] held_len;
    @(negedge clk);
    apply(op, m);
    @(negedge clk);
    verify(op, m);
    held_vec = out_vec;
    held_len = out_len;
    // idle cycle with scrambled inputs
    in_valid = 1'b0;
    in_op    = ~in_op;
    in_mask  = ~in_mask;
    in_src   = ~in_src;
    in_old   = ~in_old;
    @(negedge clk);
    check("R6", W'(out_done), W'(0), -1);
    tests++;
    if (out_vec !== held_vec || out_len !== held_len) begin
      fails++;
      $display("FAIL R7: actual len %0d expected len %0d (vector changed while idle)",
               out_len, held_len);
    end
  endtask

  initial begin
    tests = 0;
    fails = 0;
    finished = 0;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_op    = 1'b0;
    in_mask  = '0;
    in_src   = '0;
    in_old   = '0;
    repeat (3) @(negedge clk);
    // R8: reset state
    check("R8", W'(out_done), W'(0), -1);
    check("R8", W'(out_len), W'(0), -1);
    for (int i = 0; i < N; i++) check("R8", out_vec[i*W +: W], '0, i);
    rst_n = 1'b1;
    @(negedge clk);
    check("R6", W'(out_done), W'(0), -1);

    for (int op = 0; op < 2; op++)
      for (int m = 0; m < (1 << N); m++)
        one_request(op, m);

    // back-to-back requests: each result belongs to its own request
    @(negedge clk);
    apply(0, 8'b1011_0010);
    @(negedge clk);
    verify(0, 8'b1011_0010);
    apply(1, 8'b1011_0010);
    @(negedge clk);
    verify(1, 8'b1011_0010);
    in_valid = 1'b0;
    @(negedge clk);
    check("R6", W'(out_done), W'(0), -1);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: run did not complete, actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule